// File: doc/BRIEF.md
# String Operation Repeat Sequencer

This block is the control engine for a repeated string instruction. A single `start_i` pulse hands it an operation, an element size, an address width, a repeat mode, a direction, an element count and the source, destination, accumulator and port operands. The engine then works through the elements one at a time. For each element it issues the reads and writes that the operation needs over a valid/ready request channel, and it collects read data from a response strobe.

After every element the block moves the pointers that the operation uses and, in a repeat mode, lowers the count. It runs a compare or scan element through a size-masked subtractor that yields a zero flag, and it ends the sequence when the count runs out or when the compare-based exit condition is met. At the end it pulses `done_o` and presents the final count, pointers, accumulator and zero flag. The consumer copies these values back into its architectural state.

Operation codes on `op_i` are: 0 move, 1 compare, 2 scan, 3 store, 4 load, 5 port-in, 6 port-out. `size_i` takes 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. `rep_i` takes 0 for no repeat, 1 for repeat-while-equal, 2 for repeat-while-not-equal, and 3 behaves as no repeat. `wide_addr_i` set selects 32-bit pointers and count; clear selects 16-bit.

Top module: `strseq_top`

## Requirements
- R1: After each element, every pointer the operation uses moves by the element size in bytes (1, 2 or 4): down when `down_i` is set, up otherwise. Move and compare step both pointers. Scan, store and port-in step only the destination. Load and port-out step only the source.
- R2: In a repeat mode (rep 1 or 2), the count is lowered by one after every element, and the sequence ends when the lowered count reaches zero.
- R3: In a repeat mode with an initial count of zero at the selected address width, no request is issued, `done_o` follows, and the count, pointers, accumulator and memory are unchanged.
- R4: Under rep 1, a compare or scan sequence ends after the first element whose masked difference is nonzero, leaving `zf_o` at 0.
- R5: Under rep 2, a compare or scan sequence ends after the first element whose masked difference is zero, leaving `zf_o` at 1.
- R6: Move, store, load, port-in and port-out ignore the zero-flag exit under both rep 1 and rep 2, and run until the count reaches zero.
- R7: With `wide_addr_i` clear, the count and pointers wrap within their low 16 bits and their upper bits are preserved. The zero test of the count also looks only at the low 16 bits.
- R8: Move copies source memory to destination memory. Compare subtracts the destination element from the source element. Scan subtracts the destination element from the accumulator. Store writes the accumulator to the destination. Load replaces only the element-size low bytes of the accumulator with source data. Port-in writes port data (request with `req_io_o`=1 at `port_i`) to the destination. Port-out sends source data to the port. All data is masked to the element size.
- R9: With no repeat (rep 0 or 3), exactly one element is processed whatever the count, and the count is left unchanged.
- R10: `done_o` is high for exactly one cycle at the end of every sequence, with the final values on the result outputs. `zf_o` is cleared at start and is changed only by compare and scan elements.
- R11: While `req_valid_o` is high and `req_ready_i` low, the request and its address and direction hold stable. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (accepted when idle) |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Element size code |
| wide_addr_i | input | 1 | 1: 32-bit pointers and count, 0: 16-bit |
| rep_i | input | 2 | Repeat mode |
| down_i | input | 1 | Pointers step downward when set |
| count_i | input | ADDR_W | Initial element count |
| src_i | input | ADDR_W | Initial source pointer |
| dst_i | input | ADDR_W | Initial destination pointer |
| acc_i | input | DATA_W | Initial accumulator |
| port_i | input | PORT_W | Port number for port operations |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_write_o | output | 1 | 1: write, 0: read |
| req_io_o | output | 1 | Request targets port space |
| req_addr_o | output | ADDR_W | Memory address or zero-extended port number |
| req_size_o | output | 2 | Element size code of the request |
| req_wdata_o | output | DATA_W | Write data, masked to element size |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | DATA_W | Read data, low bytes significant |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| count_o | output | ADDR_W | Current or final count |
| src_o | output | ADDR_W | Current or final source pointer |
| dst_o | output | ADDR_W | Current or final destination pointer |
| acc_o | output | DATA_W | Current or final accumulator |
| zf_o | output | 1 | Last compare or scan zero flag |

## Verification
With the request channel ready, an element costs one cycle per access plus one response cycle per read, one step cycle, and one evaluation cycle at the start. `done_o` rises the cycle after the final step, or two cycles after start for a zero-count repeat. Because the bench throttles `req_ready_i` with a pseudo-random pattern, it does not predict an absolute cycle. Its monitor instead samples on the falling edge of the cycle in which `done_o` is high, and compares the results, the whole memory image and the port traffic against the queued expectation at that point. Per-cycle rules such as request hold, the single-cycle pulse and the frozen upper halves are covered by clocked properties inside the design.

// File: rtl/strseq_pkg.sv
package strseq_pkg;
  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_STORE = 3'd3,
    OP_LOAD  = 3'd4,
    OP_PIN   = 3'd5,
    OP_POUT  = 3'd6
  } str_op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_EQ   = 2'd1,
    RP_NE   = 2'd2,
    RP_RSVD = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_REQ_A, ST_RSP_A, ST_REQ_B, ST_RSP_B, ST_STEP, ST_DONE
  } st_e;
endpackage

// File: rtl/strseq_wrap_step.sv
module strseq_wrap_step #(
  parameter int unsigned W       = 32,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [2:0]   amt_i,
  input  logic         down_i,
  input  logic         wide_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] delta, full;
  assign delta = W'(amt_i);
  assign full  = down_i ? val_i - delta : val_i + delta;

  generate
    if (W > SHORT_W) begin : g_split
      logic [SHORT_W-1:0] low;
      assign low   = down_i ? val_i[SHORT_W-1:0] - delta[SHORT_W-1:0]
                            : val_i[SHORT_W-1:0] + delta[SHORT_W-1:0];
      // narrow mode keeps the upper bits untouched
      assign val_o = wide_i ? full : {val_i[W-1:SHORT_W], low};
    end else begin : g_flat
      logic unused_wide;
      assign unused_wide = wide_i;
      assign val_o = full;
    end
  endgenerate
endmodule

// File: rtl/strseq_sub.sv
module strseq_sub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] mask_i,
  output logic         zf_o
);
  logic [W-1:0] diff;
  assign diff = (a_i - b_i) & mask_i;
  assign zf_o = ~|diff;
endmodule

// File: rtl/strseq_top.sv
module strseq_top
  import strseq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              wide_addr_i,
  input  logic [1:0]        rep_i,
  input  logic              down_i,
  input  logic [ADDR_W-1:0] count_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic              req_io_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [1:0]        req_size_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] count_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zf_o
);
  st_e               st_q;
  str_op_e           op_q;
  rep_e              rep_q;
  logic [1:0]        size_q;
  logic              wide_q, down_q, zf_q;
  logic [ADDR_W-1:0] cnt_q, src_q, dst_q;
  logic [DATA_W-1:0] acc_q, buf_q;
  logic [PORT_W-1:0] port_q;

  function automatic logic low_zero(input logic [ADDR_W-1:0] v, input logic wide);
    return wide ? (v == '0) : (v[SHORT_W-1:0] == '0);
  endfunction

  // operation decode
  logic rep_on, cmp_like, uses_src, uses_dst, has_b;
  logic a_write, a_io, b_write, b_io;
  logic [ADDR_W-1:0] a_addr, b_addr, port_addr;
  logic [DATA_W-1:0] mask;
  logic [2:0] step_amt;

  assign rep_on    = (rep_q == RP_EQ) || (rep_q == RP_NE);
  assign cmp_like  = (op_q == OP_CMP) || (op_q == OP_SCAN);
  assign uses_src  = op_q inside {OP_MOVE, OP_CMP, OP_LOAD, OP_POUT};
  assign uses_dst  = op_q inside {OP_MOVE, OP_CMP, OP_SCAN, OP_STORE, OP_PIN};
  assign has_b     = op_q inside {OP_MOVE, OP_CMP, OP_PIN, OP_POUT};
  assign port_addr = ADDR_W'(port_q);
  assign a_write   = (op_q == OP_STORE);
  assign a_io      = (op_q == OP_PIN);
  assign a_addr    = (op_q == OP_SCAN || op_q == OP_STORE) ? dst_q :
                     (op_q == OP_PIN) ? port_addr : src_q;
  assign b_write   = (op_q != OP_CMP);
  assign b_io      = (op_q == OP_POUT);
  assign b_addr    = (op_q == OP_POUT) ? port_addr : dst_q;
  assign mask      = (size_q == 2'd0) ? DATA_W'(8'hFF) :
                     (size_q == 2'd1) ? DATA_W'(16'hFFFF) : '1;
  assign step_amt  = (size_q == 2'd0) ? 3'd1 : (size_q == 2'd1) ? 3'd2 : 3'd4;

  // next pointers and count
  logic [ADDR_W-1:0] src_nx, dst_nx, cnt_nx;
  strseq_wrap_step #(.W(ADDR_W), .SHORT_W(SHORT_W)) u_src_step (
    .val_i(src_q), .amt_i(step_amt), .down_i(down_q), .wide_i(wide_q), .val_o(src_nx));
  strseq_wrap_step #(.W(ADDR_W), .SHORT_W(SHORT_W)) u_dst_step (
    .val_i(dst_q), .amt_i(step_amt), .down_i(down_q), .wide_i(wide_q), .val_o(dst_nx));
  strseq_wrap_step #(.W(ADDR_W), .SHORT_W(SHORT_W)) u_cnt_step (
    .val_i(cnt_q), .amt_i(3'd1), .down_i(1'b1), .wide_i(wide_q), .val_o(cnt_nx));

  // compare datapath: scan uses the accumulator, compare the first read
  logic zf_new;
  strseq_sub #(.W(DATA_W)) u_sub (
    .a_i((op_q == OP_SCAN) ? acc_q : buf_q), .b_i(rsp_data_i),
    .mask_i(mask), .zf_o(zf_new));

  logic stop;
  assign stop = !rep_on || low_zero(cnt_nx, wide_q) ||
                (cmp_like && rep_q == RP_EQ && !zf_q) ||
                (cmp_like && rep_q == RP_NE &&  zf_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_MOVE;
      rep_q  <= RP_NONE;
      size_q <= '0;
      wide_q <= 1'b0;
      down_q <= 1'b0;
      zf_q   <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      acc_q  <= '0;
      buf_q  <= '0;
      port_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          op_q   <= str_op_e'(op_i);
          rep_q  <= rep_e'(rep_i);
          size_q <= size_i;
          wide_q <= wide_addr_i;
          down_q <= down_i;
          cnt_q  <= count_i;
          src_q  <= src_i;
          dst_q  <= dst_i;
          acc_q  <= acc_i;
          port_q <= port_i;
          zf_q   <= 1'b0;
          st_q   <= ST_EVAL;
        end
        ST_EVAL: st_q <= (rep_on && low_zero(cnt_q, wide_q)) ? ST_DONE : ST_REQ_A;
        ST_REQ_A: if (req_ready_i) st_q <= a_write ? ST_STEP : ST_RSP_A;
        ST_RSP_A: if (rsp_valid_i) begin
          buf_q <= rsp_data_i & mask;
          if (op_q == OP_LOAD) acc_q <= (acc_q & ~mask) | (rsp_data_i & mask);
          if (op_q == OP_SCAN) zf_q <= zf_new;
          st_q <= has_b ? ST_REQ_B : ST_STEP;
        end
        ST_REQ_B: if (req_ready_i) st_q <= b_write ? ST_STEP : ST_RSP_B;
        ST_RSP_B: if (rsp_valid_i) begin
          zf_q <= zf_new;
          st_q <= ST_STEP;
        end
        ST_STEP: begin
          if (uses_src) src_q <= src_nx;
          if (uses_dst) dst_q <= dst_nx;
          if (rep_on)   cnt_q <= cnt_nx;
          st_q <= stop ? ST_DONE : ST_REQ_A;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == ST_REQ_A) || (st_q == ST_REQ_B);
  assign req_write_o = (st_q == ST_REQ_B) ? b_write : a_write;
  assign req_io_o    = req_valid_o && ((st_q == ST_REQ_B) ? b_io : a_io);
  assign req_addr_o  = (st_q == ST_REQ_B) ? b_addr : a_addr;
  assign req_size_o  = size_q;
  assign req_wdata_o = ((op_q == OP_STORE) ? acc_q : buf_q) & mask;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign count_o     = cnt_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign acc_o       = acc_q;
  assign zf_o        = zf_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_write_o))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R10
  AST_ZERO_COUNT_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EVAL && rep_on && low_zero(cnt_q, wide_q)) |=> (done_o && !req_valid_o)); // R3
  AST_NOREP_COUNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rep_on) |=> $stable(cnt_q)); // R9
  AST_ZF_ONLY_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmp_like) |=> $stable(zf_q)); // R10

  generate
    if (ADDR_W > SHORT_W) begin : g_narrow_chk
      AST_UPPER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !wide_q) |=> ($stable(cnt_q[ADDR_W-1:SHORT_W]) &&
                                 $stable(src_q[ADDR_W-1:SHORT_W]) &&
                                 $stable(dst_q[ADDR_W-1:SHORT_W]))); // R7
    end
  endgenerate
endmodule

// File: tb/strseq_top_test.sv
module strseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic        wide = 1'b1;
  logic [1:0]  rep = '0;
  logic        down = 1'b0;
  logic [31:0] count = '0, src = '0, dst = '0, acc = '0;
  logic [15:0] port = '0;
  logic        req_valid, req_write, req_io, busy, done, zf;
  logic        req_ready;
  logic [31:0] req_addr, req_wdata, count_o, src_o, dst_o, acc_o;
  logic [1:0]  req_size;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;

  always #2 clk = ~clk;

  strseq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .size_i(size),
    .wide_addr_i(wide), .rep_i(rep), .down_i(down), .count_i(count),
    .src_i(src), .dst_i(dst), .acc_i(acc), .port_i(port),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
    .req_io_o(req_io), .req_addr_o(req_addr), .req_size_o(req_size),
    .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .busy_o(busy), .done_o(done), .count_o(count_o), .src_o(src_o),
    .dst_o(dst_o), .acc_o(acc_o), .zf_o(zf));

  typedef struct {
    string       name;
    logic [31:0] cnt, s, d, a, psum;
    logic        zf;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0, n_push = 0, n_pop = 0;
  logic [7:0]  mem [256];
  logic [7:0]  ref_mem [256];
  logic [7:0]  dut_pseq = 8'd0, ref_pseq = 8'd0;
  logic [31:0] dut_psum = '0, ref_psum = '0;
  logic [7:0]  lfsr = 8'h5A;

  assign req_ready = lfsr[0] | lfsr[1];

  function automatic logic [31:0] pdata(input logic [7:0] k);
    return {k + 8'h30, k + 8'h20, k + 8'h10, k};
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] szmask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // memory and port responder
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      if (!req_write) begin
        rsp_valid <= 1'b1;
        if (req_io) begin
          rsp_data <= pdata(dut_pseq);
          dut_pseq <= dut_pseq + 8'd1;
        end else begin
          logic [31:0] rd;
          rd = '0;
          for (int j = 0; j < nbytes(req_size); j++) rd[j*8 +: 8] = mem[8'(req_addr + 32'(j))];
          rsp_data <= rd;
        end
      end else if (req_io) begin
        dut_psum <= dut_psum + (req_wdata ^ {16'h0, req_addr[15:0]});
      end else begin
        for (int j = 0; j < nbytes(req_size); j++) mem[8'(req_addr + 32'(j))] <= req_wdata[j*8 +: 8];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wstep(input logic [31:0] v, input int amt,
                                        input logic dn, input logic wd);
    logic [31:0] f;
    logic [15:0] l;
    f = dn ? v - 32'(amt) : v + 32'(amt);
    l = dn ? v[15:0] - 16'(amt) : v[15:0] + 16'(amt);
    return wd ? f : {v[31:16], l};
  endfunction

  function automatic logic lowz(input logic [31:0] v, input logic wd);
    return wd ? (v == 0) : (v[15:0] == 0);
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] ad, input int nb);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < nb; j++) r[j*8 +: 8] = ref_mem[8'(ad + 32'(j))];
    return r;
  endfunction

  task automatic ref_wr(input logic [31:0] ad, input logic [31:0] v, input int nb);
    for (int j = 0; j < nb; j++) ref_mem[8'(ad + 32'(j))] = v[j*8 +: 8];
  endtask

  task automatic poke(input logic [7:0] ad, input logic [7:0] v);
    mem[ad] = v;
    ref_mem[ad] = v;
  endtask

  // reference model built from R1..R10
  task automatic ref_run(input string name, input logic [2:0] o, input logic [1:0] sz,
                         input logic wd, input logic [1:0] rp, input logic dn,
                         input logic [31:0] c0, s0, d0, a0, input logic [15:0] pt,
                         output exp_t e);
    logic [31:0] c, s, d, a, v, b, m;
    logic z, on, stp;
    int nb, guard;
    c = c0; s = s0; d = d0; a = a0; z = 1'b0;
    nb = nbytes(sz); m = szmask(sz);
    on = (rp == 2'd1) || (rp == 2'd2);
    guard = 0;
    if (!(on && lowz(c, wd))) begin
      stp = 1'b0;
      while (!stp && guard < 1000) begin
        guard++;
        case (o)
          3'd0: begin v = ref_rd(s, nb); ref_wr(d, v, nb); end
          3'd1: begin v = ref_rd(s, nb); b = ref_rd(d, nb); z = (((v - b) & m) == 0); end
          3'd2: begin b = ref_rd(d, nb); z = (((a - b) & m) == 0); end
          3'd3: ref_wr(d, a & m, nb);
          3'd4: begin v = ref_rd(s, nb); a = (a & ~m) | v; end
          3'd5: begin v = pdata(ref_pseq) & m; ref_pseq = ref_pseq + 8'd1; ref_wr(d, v, nb); end
          default: begin v = ref_rd(s, nb); ref_psum = ref_psum + ((v & m) ^ {16'h0, pt}); end
        endcase
        if (o == 3'd0 || o == 3'd1 || o == 3'd4 || o == 3'd6) s = wstep(s, nb, dn, wd);
        if (o == 3'd0 || o == 3'd1 || o == 3'd2 || o == 3'd3 || o == 3'd5) d = wstep(d, nb, dn, wd);
        if (!on) stp = 1'b1;
        else begin
          c = wstep(c, 1, 1'b1, wd);
          if (lowz(c, wd)) stp = 1'b1;
          if ((o == 3'd1 || o == 3'd2) && rp == 2'd1 && !z) stp = 1'b1;
          if ((o == 3'd1 || o == 3'd2) && rp == 2'd2 && z) stp = 1'b1;
        end
      end
    end
    e.name = name; e.cnt = c; e.s = s; e.d = d; e.a = a; e.zf = z; e.psum = ref_psum;
  endtask

  task automatic run(input string name, input logic [2:0] o, input logic [1:0] sz,
                     input logic wd, input logic [1:0] rp, input logic dn,
                     input logic [31:0] c0, s0, d0, a0, input logic [15:0] pt);
    exp_t e;
    ref_run(name, o, sz, wd, rp, dn, c0, s0, d0, a0, pt, e);
    exp_q.push_back(e);
    n_push++;
    @(negedge clk);
    op = o; size = sz; wide = wd; rep = rp; down = dn;
    count = c0; src = s0; dst = d0; acc = a0; port = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (n_pop != n_push) @(negedge clk);
  endtask

  // monitor: compare at the falling edge of the done cycle
  initial begin
    forever begin
      @(negedge clk);
      if (done && exp_q.size() > 0) begin
        exp_t e;
        int diffs;
        e = exp_q.pop_front();
        chk({e.name, " R2 count"}, count_o, e.cnt);
        chk({e.name, " R1 src"}, src_o, e.s);
        chk({e.name, " R1 dst"}, dst_o, e.d);
        chk({e.name, " R8 acc"}, acc_o, e.a);
        chk({e.name, " R10 zf"}, {31'h0, zf}, {31'h0, e.zf});
        chk({e.name, " R8 port"}, dut_psum, e.psum);
        diffs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diffs++;
        chk({e.name, " R8 memory"}, 32'(diffs), 32'd0);
        @(negedge clk);
        chk({e.name, " R10 pulse"}, {31'h0, done}, 32'd0);
        n_pop++;
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(negedge clk); cyc++; end
    n_bad++;
    $display("FAIL R10 watchdog: actual no finish expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk("R10 reset busy", {31'h0, busy}, 32'd0);
    chk("R11 reset req", {31'h0, req_valid}, 32'd0);
    chk("R10 reset done", {31'h0, done}, 32'd0);
    rst_n = 1'b1;

    // R1 R2: move up, 2-byte, then move down 4-byte
    run("move_up", 3'd0, 2'd1, 1'b1, 2'd1, 1'b0, 32'd4, 32'h10, 32'h30, 32'h0, 16'h0);
    run("move_dn", 3'd0, 2'd2, 1'b1, 2'd2, 1'b1, 32'd3, 32'h6C, 32'hEC, 32'h0, 16'h0);
    // R4: compare while equal, mismatch at 4th element
    for (int i = 0; i < 6; i++) begin poke(8'h40 + 8'(i), 8'(i + 1)); poke(8'h80 + 8'(i), 8'(i + 1)); end
    poke(8'h43, 8'h09);
    run("cmp_repe", 3'd1, 2'd0, 1'b1, 2'd1, 1'b0, 32'd6, 32'h40, 32'h80, 32'h0, 16'h0);
    // R5: compare while not equal, match at 3rd element
    for (int i = 0; i < 5; i++) begin poke(8'h50 + 8'(i), 8'(i + 1)); poke(8'h90 + 8'(i), 8'h09); end
    poke(8'h92, 8'h03);
    run("cmp_repne", 3'd1, 2'd0, 1'b1, 2'd2, 1'b0, 32'd5, 32'h50, 32'h90, 32'h0, 16'h0);
    // R5: scan for a byte
    poke(8'hA0, 8'h01); poke(8'hA1, 8'h02); poke(8'hA2, 8'h77);
    run("scan_repne", 3'd2, 2'd0, 1'b1, 2'd2, 1'b0, 32'd8, 32'h0, 32'hA0, 32'hDEAD_BE77, 16'h0);
    // R4: scan words while equal to accumulator
    poke(8'hB0, 8'h34); poke(8'hB1, 8'h12); poke(8'hB2, 8'h34); poke(8'hB3, 8'h12);
    poke(8'hB4, 8'h00); poke(8'hB5, 8'h00);
    run("scan_repe", 3'd2, 2'd1, 1'b1, 2'd1, 1'b0, 32'd5, 32'h0, 32'hB0, 32'hFFFF_1234, 16'h0);
    // R6: store and load ignore the zero-flag exit
    run("store_repne", 3'd3, 2'd0, 1'b1, 2'd2, 1'b0, 32'd5, 32'h0, 32'hC0, 32'hAABB_CC5E, 16'h0);
    run("load_repe", 3'd4, 2'd0, 1'b1, 2'd1, 1'b0, 32'd3, 32'h20, 32'h0, 32'h1122_3344, 16'h0);
    // R8: port traffic
    run("port_in", 3'd5, 2'd1, 1'b1, 2'd1, 1'b0, 32'd3, 32'h0, 32'hD0, 32'h0, 16'h03F8);
    run("port_out", 3'd6, 2'd2, 1'b1, 2'd2, 1'b1, 32'd2, 32'h18, 32'h0, 32'h0, 16'h0080);
    // R3: zero count with repeat, including narrow count with upper bits set
    run("zero_cnt", 3'd0, 2'd0, 1'b1, 2'd1, 1'b0, 32'd0, 32'h60, 32'h70, 32'h5, 16'h0);
    run("zero_low16", 3'd3, 2'd0, 1'b0, 2'd2, 1'b0, 32'h0001_0000, 32'h0, 32'h70, 32'h5, 16'h0);
    // R9: no repeat, one element, count held
    run("norep_move", 3'd0, 2'd2, 1'b1, 2'd0, 1'b0, 32'd7, 32'h10, 32'hF0, 32'h0, 16'h0);
    run("norep_cmp", 3'd1, 2'd0, 1'b1, 2'd3, 1'b0, 32'd0, 32'h40, 32'h80, 32'h0, 16'h0);
    // R7: 16-bit wrap up and down
    run("wrap_up", 3'd0, 2'd1, 1'b0, 2'd1, 1'b0, 32'hABCD_0002, 32'h1234_FFFE, 32'h5678_0010, 32'h0, 16'h0);
    run("wrap_dn", 3'd3, 2'd0, 1'b0, 2'd1, 1'b1, 32'h0000_0003, 32'h0, 32'h9ABC_0001, 32'h77, 16'h0);
    run("wrap_cnt", 3'd4, 2'd0, 1'b0, 2'd2, 1'b0, 32'h5555_0001, 32'h0000_FFFF, 32'h0, 32'h0, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule